// File: doc/BRIEF.md
# Sector DMA Disk Controller

This block is a bus slave that lets a processor move one fixed 128-byte sector between a sector-addressed storage port and main memory. Software writes long words to set the main-memory buffer address and the drive number, then writes the sector number to one of two command offsets. That write is itself the command: it loads the sector, checks the drive and sector against the configured geometry, and, if both are in range, starts a byte-by-byte DMA transfer. There is no track or head field; the storage side sees only a drive, a sector and a byte index within the sector.

The transfer runs on a byte-wide master port. It issues one request per byte and advances only when the memory side grants it. Bytes are moved in ascending address order from the buffer address, and the address wraps within the master address width. While a transfer runs, the block is busy, and every register write is ignored. A status offset can still be read as a word or a long word. A separate offset sends a one-cycle flush request to the storage side.

Status codes, held in the low two bits of the status value: 0 = last operation completed without error, 1 = drive number out of range, 2 = sector number out of range, 3 = transfer in progress.

Top module: `sdma_ctrl`

## Requirements
- R1: After reset the status reads 0, busy is low, no memory request is made and the flush output is low.
- R2: A long write to offset 12 (read command) with valid parameters copies the 128 storage bytes of the selected drive and sector, index 0 to 127, to main memory at buffer address + index, one byte per grant, and leaves status 0 with no byte outside that range written.
- R3: A long write to offset 16 (write command) with valid parameters reads main memory from buffer address + index and writes each byte to storage index 0 to 127 with one storage write strobe per grant, and then leaves status 0.
- R4: A long write to offset 0 sets the buffer address, to offset 4 sets the drive, and to offset 8 or to either command offset sets the sector; the drive and sector are shown on the storage-side drive and sector outputs.
- R5: A command whose drive is not below NUM_DRIVES sets status 1; otherwise a command whose sector is not below SECTORS sets status 2; in both cases no memory request and no storage write take place and busy stays low.
- R6: Reading offset 20 returns the status: a long read returns it zero-extended to 32 bits, a word read returns it in the low 16 bits, and it reads 3 from the cycle after a valid command until the transfer ends.
- R7: While busy is high, long writes to any offset are ignored: no second transfer starts and the buffer address, drive and sector keep their values.
- R8: Word-sized writes to any offset are ignored: they start no transfer, issue no flush and change no register.
- R9: A long write to offset 24 drives the flush output high for exactly one cycle.
- R10: The memory address wraps modulo 2^ADDR_W when buffer address + index passes the top of the address space.
- R11: An ungranted memory request holds its address and direction until it is granted; a transfer takes exactly 128 grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_long | input | 1 | 1 = long-word access, 0 = word access |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (status at offset 20, else 0) |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_gnt | input | 1 | Memory grant, completes the current byte |
| mem_rdata | input | 8 | Byte read from memory, valid with grant |
| st_drive | output | DRV_W | Selected drive |
| st_sector | output | SEC_W | Selected sector |
| st_idx | output | IDX_W | Byte index within the sector |
| st_we | output | 1 | Storage byte write strobe |
| st_wdata | output | 8 | Byte written to storage |
| st_rdata | input | 8 | Byte read from storage at drive, sector, index |
| st_flush | output | 1 | One-cycle flush request |

## Verification
Transfers are run in both directions with directed geometry corners (last drive and last sector, first out-of-range drive and sector, both out of range, an all-ones drive) and with random buffer addresses, drives and sectors that sometimes fall out of range. A storage pattern that mixes drive, sector and index tells apart a wrong sector, a wrong drive or a shifted byte order, and guard bytes around the buffer catch a transfer that runs one byte long or starts one byte early. A buffer placed near the top of memory separates correct address wrap from a carry into unused bits. Random grant gaps separate per-grant advance from per-cycle advance, and commands issued in the middle of a transfer, together with word-sized writes, show whether anything slips past the busy and size gating.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  // register byte offsets on the slave port
  localparam logic [4:0] OFF_DMA   = 5'd0;
  localparam logic [4:0] OFF_DRIVE = 5'd4;
  localparam logic [4:0] OFF_SECT  = 5'd8;
  localparam logic [4:0] OFF_RDCMD = 5'd12;
  localparam logic [4:0] OFF_WRCMD = 5'd16;
  localparam logic [4:0] OFF_STAT  = 5'd20;
  localparam logic [4:0] OFF_FLUSH = 5'd24;

  typedef enum logic [1:0] {
    ST_OK         = 2'd0,
    ST_BAD_DRIVE  = 2'd1,
    ST_BAD_SECTOR = 2'd2,
    ST_RUN        = 2'd3
  } sdma_status_e;

  // geometry check: drive range has precedence over sector range
  function automatic sdma_status_e param_code(input logic [31:0] drive,
                                              input logic [31:0] sector,
                                              input int unsigned n_drv,
                                              input int unsigned n_sec);
    if (drive >= n_drv)       return ST_BAD_DRIVE;
    else if (sector >= n_sec) return ST_BAD_SECTOR;
    else                      return ST_OK;
  endfunction

  // byte address of a sector index; caller truncates to its width
  function automatic logic [31:0] byte_addr(input logic [31:0] base,
                                            input logic [31:0] idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int SECTORS    = 64,
  localparam int DRV_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  localparam int SEC_W     = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_long,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic              xfer_done,
  output logic [31:0]       dma_base,
  output logic [DRV_W-1:0]  drive_idx,
  output logic [SEC_W-1:0]  sector_idx,
  output logic              start,
  output logic              start_dir,
  output logic              flush_pulse,
  output sdma_status_e      status
);

  logic [31:0]  dma_q, drive_q, sector_q;
  logic         flush_q;
  sdma_status_e status_q;

  // event wires
  logic         acc;
  logic         cmd_hit;
  sdma_status_e cmd_code;

  assign acc      = reg_wr && reg_long && !busy;
  assign cmd_hit  = acc && (reg_addr == OFF_RDCMD || reg_addr == OFF_WRCMD);
  assign cmd_code = param_code(drive_q, reg_wdata, NUM_DRIVES, SECTORS);
  assign start    = cmd_hit && (cmd_code == ST_OK);
  assign start_dir = (reg_addr == OFF_WRCMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_q    <= '0;
      drive_q  <= '0;
      sector_q <= '0;
      flush_q  <= 1'b0;
      status_q <= ST_OK;
    end else begin
      flush_q <= 1'b0;
      if (acc) begin
        case (reg_addr)
          OFF_DMA:   dma_q    <= reg_wdata;
          OFF_DRIVE: drive_q  <= reg_wdata;
          OFF_SECT,
          OFF_RDCMD,
          OFF_WRCMD: sector_q <= reg_wdata;
          OFF_FLUSH: flush_q  <= 1'b1;
          default: ;
        endcase
      end
      if (xfer_done)
        status_q <= ST_OK;
      else if (cmd_hit)
        status_q <= start ? ST_RUN : cmd_code;
    end
  end

  assign dma_base    = dma_q;
  assign drive_idx   = drive_q[DRV_W-1:0];
  assign sector_idx  = sector_q[SEC_W-1:0];
  assign flush_pulse = flush_q;
  assign status      = status_q;

  // R5
  bad_param_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_code != ST_OK) |=> (status == $past(cmd_code)) && !busy);

  // R6
  run_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (status == ST_RUN) && busy);

  // R8
  word_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_long) |=> $stable(dma_q) && $stable(drive_q) &&
                              $stable(sector_q) && !flush_q);

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && busy) |=> $stable(dma_q) && $stable(drive_q) && $stable(sector_q));

endmodule

// File: rtl/sdma_xfer.sv
module sdma_xfer
  import sdma_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int SECTOR_BYTES = 128,
  localparam int IDX_W       = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dir,
  input  logic [31:0]       dma_base,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic [IDX_W-1:0]  st_idx,
  output logic              st_we,
  output logic [7:0]        st_wdata,
  input  logic [7:0]        st_rdata
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

  logic             busy_q;
  logic             dir_q;     // 1 = memory to storage
  logic [IDX_W-1:0] idx_q;

  // event wires
  logic             last;
  logic             beat;
  logic [ADDR_W-1:0] addr_plus1;

  assign last = (idx_q == LAST_IDX);
  assign beat = busy_q && mem_gnt;
  assign done = beat && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      dir_q  <= start_dir;
      idx_q  <= '0;
    end else if (beat) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_we    = busy_q && !dir_q;
  assign mem_addr  = ADDR_W'(byte_addr(dma_base, 32'(idx_q)));
  assign mem_wdata = st_rdata;
  assign st_idx    = idx_q;
  assign st_we     = beat && dir_q;
  assign st_wdata  = mem_rdata;
  assign addr_plus1 = mem_addr + {{(ADDR_W-1){1'b0}}, 1'b1};

  // R7
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R11
  hold_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R10
  ascending_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !done) |=> mem_req && (mem_addr == $past(addr_plus1)));

  // R2
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q && !mem_req && !st_we);

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int NUM_DRIVES   = 4,
  parameter int SECTORS      = 64,
  parameter int SECTOR_BYTES = 128,
  localparam int DRV_W       = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  localparam int SEC_W       = (SECTORS > 1) ? $clog2(SECTORS) : 1,
  localparam int IDX_W       = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_long,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  output logic [DRV_W-1:0]  st_drive,
  output logic [SEC_W-1:0]  st_sector,
  output logic [IDX_W-1:0]  st_idx,
  output logic              st_we,
  output logic [7:0]        st_wdata,
  input  logic [7:0]        st_rdata,
  output logic              st_flush
);

  logic [31:0]  dma_base;
  logic         start, start_dir, xfer_done;
  sdma_status_e status;

  sdma_regs #(
    .NUM_DRIVES (NUM_DRIVES),
    .SECTORS    (SECTORS)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_long    (reg_long),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .busy        (busy),
    .xfer_done   (xfer_done),
    .dma_base    (dma_base),
    .drive_idx   (st_drive),
    .sector_idx  (st_sector),
    .start       (start),
    .start_dir   (start_dir),
    .flush_pulse (st_flush),
    .status      (status)
  );

  sdma_xfer #(
    .ADDR_W       (ADDR_W),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_dir (start_dir),
    .dma_base  (dma_base),
    .busy      (busy),
    .done      (xfer_done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .st_idx    (st_idx),
    .st_we     (st_we),
    .st_wdata  (st_wdata),
    .st_rdata  (st_rdata)
  );

  logic stat_sel;
  assign stat_sel  = reg_rd && (reg_addr == OFF_STAT);
  assign reg_rdata = !stat_sel ? 32'h0 :
                     reg_long  ? 32'(status) : {16'h0, 16'(status)};

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !st_we);

endmodule

// File: tb/sdma_ctrl_tb.sv
module sdma_ctrl_tb;

  localparam int AW = 24;
  localparam int ND = 4;
  localparam int NS = 64;
  localparam int SB = 128;
  localparam int unsigned AMASK = (1 << AW) - 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_long = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        busy, mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [1:0]  st_drive;
  logic [5:0]  st_sector;
  logic [6:0]  st_idx;
  logic        st_we, st_flush;
  logic [7:0]  st_wdata, st_rdata;

  always #10 clk = ~clk;

  sdma_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_long(reg_long), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .st_drive(st_drive), .st_sector(st_sector),
    .st_idx(st_idx), .st_we(st_we), .st_wdata(st_wdata),
    .st_rdata(st_rdata), .st_flush(st_flush)
  );

  int n_chk = 0, n_fail = 0;
  int gnt_cnt = 0, stwe_cnt = 0, flush_cnt = 0;
  int we_drv = 0, we_sec = 0;
  logic [7:0] wbuf [SB];
  logic [7:0] mem [int unsigned];
  logic [7:0] pre [SB+2];
  bit finished = 0;

  // storage content as a function of drive, sector and index
  function automatic logic [7:0] pat(input int unsigned d, input int unsigned s,
                                     input int unsigned i);
    return 8'((d * 37 + s * 11 + i * 5) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] mem_get(input int unsigned a);
    if (mem.exists(a)) return mem[a];
    return 8'(a * 3 + 1);
  endfunction

  function automatic int exp_code(input int unsigned d, input int unsigned s);
    if (d >= ND) return 1;
    if (s >= NS) return 2;
    return 0;
  endfunction

  assign st_rdata = pat(st_drive, st_sector, st_idx);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // memory and storage model
  initial begin
    mem_gnt = 1'b0;
    mem_rdata = 8'h0;
    forever begin
      @(negedge clk);
      mem_gnt = ($urandom % 4) != 0;
      mem_rdata = mem_get(mem_addr);
      #1;
      if (mem_req && mem_gnt) begin
        gnt_cnt++;
        if (mem_we) mem[mem_addr] = mem_wdata;
      end
      if (st_we) begin
        stwe_cnt++;
        wbuf[st_idx] = st_wdata;
        we_drv = st_drive;
        we_sec = st_sector;
      end
      if (st_flush) flush_cnt++;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit lng = 1'b1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_long = lng;
    @(negedge clk);
    reg_wr = 1'b0; reg_long = 1'b1;
  endtask

  task automatic rd_st(input bit lng, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 5'd20; reg_long = lng;
    #2;
    v = reg_rdata;
    reg_rd = 1'b0; reg_long = 1'b1;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  // one command with full checking; dir 1 = write command
  task automatic run_op(input bit dir, input int unsigned dma,
                        input int unsigned drv, input int unsigned sec);
    logic [31:0] v;
    int code, bad;
    dma = dma & AMASK;
    wr(5'd0, dma);
    wr(5'd4, drv);
    for (int i = 0; i < SB + 2; i++) begin
      int unsigned a = (dma + i - 1) & AMASK;
      mem[a] = 8'($urandom);
      pre[i] = mem[a];
    end
    gnt_cnt = 0; stwe_cnt = 0;
    code = exp_code(drv, sec);
    wr(dir ? 5'd16 : 5'd12, sec);
    if (code != 0) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R5 busy after bad params", busy, 0);
      check(gnt_cnt == 0 && stwe_cnt == 0, "R5 no traffic on bad params",
            gnt_cnt + stwe_cnt, 0);
      rd_st(1'b1, v);
      check(v == 32'(code), "R5 error status", v, code);
    end else begin
      rd_st(1'b1, v);
      check(v == 32'd3 && busy, "R6 status while running", v, 3);
      wait_idle();
      rd_st(1'b1, v);
      check(v == 32'd0, dir ? "R3 status after write" : "R2 status after read", v, 0);
      check(gnt_cnt == SB, "R11 grant count", gnt_cnt, SB);
      check(st_sector == 6'(sec), "R4 sector from command", st_sector, sec);
      if (!dir) begin
        bad = 0;
        for (int i = 0; i < SB; i++)
          if (mem_get((dma + i) & AMASK) != pat(drv, sec, i)) bad++;
        check(bad == 0, "R2 sector bytes in memory (R10 wrap)", bad, 0);
        check(mem_get((dma - 1) & AMASK) == pre[0] &&
              mem_get((dma + SB) & AMASK) == pre[SB+1],
              "R2 guard bytes untouched", mem_get((dma + SB) & AMASK), pre[SB+1]);
      end else begin
        bad = 0;
        for (int i = 0; i < SB; i++)
          if (wbuf[i] != pre[i+1]) bad++;
        check(bad == 0, "R3 storage bytes from memory", bad, 0);
        check(stwe_cnt == SB, "R3 storage write count", stwe_cnt, SB);
        check(we_drv == int'(drv) && we_sec == int'(sec), "R3 storage drive/sector",
              we_drv * 256 + we_sec, drv * 256 + sec);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'h5EED_0001));
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && mem_req == 1'b0 && st_flush == 1'b0, "R1 idle outputs",
          {busy, mem_req, st_flush}, 0);
    rd_st(1'b1, v);
    check(v == 32'd0, "R1 reset status", v, 0);

    // R4 sector register and drive register on storage outputs
    wr(5'd8, 32'd17);
    wr(5'd4, 32'd2);
    check(st_sector == 6'd17 && st_drive == 2'd2, "R4 drive/sector registers",
          {st_drive, st_sector}, {2'd2, 6'd17});

    // directed transfers and geometry corners
    run_op(1'b0, 32'h000100, 0, 0);
    run_op(1'b1, 32'h000400, 1, 3);
    run_op(1'b0, 32'h001000, ND - 1, NS - 1);
    run_op(1'b1, 32'h002000, ND - 1, NS - 1);
    run_op(1'b0, 32'h003000, ND, 0);
    run_op(1'b1, 32'h003000, 0, NS);
    run_op(1'b0, 32'h003000, ND + 3, NS + 5);
    run_op(1'b0, 32'h003000, 32'hFFFF_FFFF, 0);
    // R10 wrap at the top of the address space
    run_op(1'b0, AMASK - 63, 2, 9);
    run_op(1'b1, AMASK - 10, 3, 40);

    // R6 word read of status after a sector error
    run_op(1'b0, 32'h000000, 0, NS + 1);
    rd_st(1'b0, v);
    check(v == 32'd2, "R6 word status read", v, 2);

    // R8 word writes are ignored
    gnt_cnt = 0; flush_cnt = 0;
    wr(5'd4, 32'd1);
    wr(5'd12, 32'd5, 1'b0);
    wr(5'd4, 32'd3, 1'b0);
    wr(5'd24, 32'd0, 1'b0);
    repeat (2) @(negedge clk);
    rd_st(1'b1, v);
    check(busy == 1'b0 && gnt_cnt == 0, "R8 word command starts nothing", gnt_cnt, 0);
    check(v == 32'd2, "R8 status unchanged", v, 2);
    check(st_drive == 2'd1, "R8 drive unchanged", st_drive, 1);
    check(flush_cnt == 0, "R8 word flush ignored", flush_cnt, 0);

    // R9 flush pulse
    flush_cnt = 0;
    wr(5'd24, 32'd0);
    repeat (3) @(negedge clk);
    check(flush_cnt == 1, "R9 one flush pulse", flush_cnt, 1);

    // R7 writes during a transfer are ignored
    wr(5'd0, 32'h004000);
    wr(5'd4, 32'd1);
    gnt_cnt = 0;
    wr(5'd12, 32'd5);
    wr(5'd4, 32'd2);
    wr(5'd16, 32'd9);
    wr(5'd0, 32'h008000);
    wr(5'd8, 32'd33);
    check(busy == 1'b1, "R7 still busy", busy, 1);
    wait_idle();
    check(gnt_cnt == SB, "R7 no second transfer", gnt_cnt, SB);
    check(st_drive == 2'd1 && st_sector == 6'd5, "R7 drive/sector held",
          {st_drive, st_sector}, {2'd1, 6'd5});
    gnt_cnt = 0;
    wr(5'd12, 32'd6);
    wait_idle();
    v2 = 0;
    for (int i = 0; i < SB; i++)
      if (mem_get(32'h004000 + i) != pat(1, 6, i)) v2++;
    check(v2 == 0, "R7 buffer address held", v2, 0);

    // constrained random mix
    for (int k = 0; k < 10; k++) begin
      run_op(1'($urandom % 2), $urandom, $urandom % (ND + 1), $urandom % (NS + 2));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule